// File: doc/BRIEF.md
# Address Range Steering Resolver

This unit picks the group and instance identifiers that steer a read of a replicated register to a copy that is present and powered. A register offset is classified against five steering classes. Each class owns a small table of inclusive address ranges. The classes are examined in a fixed priority and the first one that matches decides the identifiers. Each class has its own rule for deriving identifiers from the unit-enable masks. When no class claims the offset, the programmable default identifiers are returned instead.

Software fills the range tables one slot at a time through a write-only configuration port. The enable masks and the default identifiers are supplied as live inputs. A lookup is presented with `req_valid`. Exactly one clock later the registered answer appears together with `rsp_valid`. Offsets inside a secondary address window are rebased by a fixed offset before they are compared with the tables.

Top module: `steer_resolver`

## Requirements
- R1: A table slot matches when it is enabled and lo <= offset <= hi, with both bounds included. A disabled slot never matches. Reset disables every slot.
- R2: Class codes are L3 bank = 0, memory slice = 1, LNCF = 2, compute unit = 3 and fixed-zero = 4. Priority runs from code 0 upward, and the lowest-coded matching class is reported on `rsp_class` with `rsp_hit` = 1.
- R3: When no class matches, the outputs are `rsp_hit` = 0, `rsp_class` = 7, `rsp_err` = 0, and `rsp_group`/`rsp_inst` equal `dflt_group`/`dflt_inst` as sampled with the request.
- R4: An offset between WIN_LO and WIN_HI inclusive (default 0x38000 to 0x3FFFF) has WIN_BASE (default 0x380000) added before comparison. Any other offset is compared unchanged.
- R5: L3 bank class: fuse bit i of `l3_fuse` enables banks 2i and 2i+1. The group is 0 and the instance is the index of the lowest enabled bank.
- R6: A memory slice k is present when `meml3_en[k]` is set or any of `cu_en[k*4 +: 4]` is set (default of 4 units per slice). The memory slice class gives group = lowest present slice and instance = 0. The LNCF class gives group = twice that index and instance = 0.
- R7: Compute unit class: with f the lowest set bit of `cu_en`, the group is f / CU_PER_GROUP and the instance is f % CU_PER_GROUP (default 4).
- R8: Fixed-zero class: the group and instance are both 0, and `rsp_err` is 0.
- R9: If the winning class among codes 0 to 3 has an all-zero source mask, the group and instance are 0 and `rsp_err` = 1.
- R10: The response registers load on the clock edge that samples `req_valid`. `rsp_valid` is `req_valid` delayed by one cycle. The response fields hold their value when no request is made.
- R11: A configuration write (`cfg_we`) stores `cfg_lo`, `cfg_hi` and `cfg_en` into slot `cfg_slot` of class `cfg_class`. A lookup in the same cycle still sees the old slot contents. Lookups from the next cycle on see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one table slot |
| cfg_class | input | 3 | Class code of the table written |
| cfg_slot | input | 4 | Slot index within the table |
| cfg_lo | input | 22 | Inclusive lower bound |
| cfg_hi | input | 22 | Inclusive upper bound |
| cfg_en | input | 1 | Slot enable (0 clears the slot) |
| l3_fuse | input | 3 | L3 bank pair enables |
| meml3_en | input | 4 | Memory-slice memory enables |
| cu_en | input | 16 | Compute-unit enables |
| dflt_group | input | 4 | Default group identifier |
| dflt_inst | input | 4 | Default instance identifier |
| req_valid | input | 1 | Lookup request |
| req_offset | input | 22 | Register offset to resolve |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | A class matched |
| rsp_class | output | 3 | Winning class code, 7 if none |
| rsp_group | output | 4 | Steering group identifier |
| rsp_inst | output | 4 | Steering instance identifier |
| rsp_err | output | 1 | Winning class had an empty mask |

## Verification
The hardest situation to create from the ports is a configuration write and a lookup that land in the same cycle on a slot the lookup depends on. The bench drives both on one falling edge: it disables the L3 slot while looking up an offset that a lower-priority compute-unit range also covers. It then expects the old L3 answer first and the compute-unit answer on the following lookup. Overlapping ranges of different classes, window-rebased offsets and sweeps over every fuse and slice mask, plus a walking compute-unit mask, cover the priority order, each identifier rule and the empty-mask error.

// File: rtl/steer_pkg.sv
// Package: shared class codes for the steering resolver.
// Assumes class codes are contiguous from 0 in priority order.
package steer_pkg;
    localparam int N_CLASS = 5;

    typedef enum logic [2:0] {
        CLS_L3     = 3'd0,
        CLS_MSLICE = 3'd1,
        CLS_LNCF   = 3'd2,
        CLS_CU     = 3'd3,
        CLS_ZERO   = 3'd4,
        CLS_NONE   = 3'd7
    } steer_class_e;
endpackage

// File: rtl/steer_range_table.sv
// Module: one class's table of inclusive address ranges.
// Holds N_RANGES slots (lo, hi, enable), written one at a time, and
// reports whether a probe address falls in any enabled slot.
// Assumes slot indices at or above N_RANGES are never written.
module steer_range_table #(
    parameter int ADDR_W   = 22,
    parameter int N_RANGES = 12,
    localparam int SLOT_W  = $clog2(N_RANGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [ADDR_W-1:0] wr_lo,
    input  logic [ADDR_W-1:0] wr_hi,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] probe,
    output logic              hit
);
    logic [ADDR_W-1:0]   lo_q [N_RANGES];
    logic [ADDR_W-1:0]   hi_q [N_RANGES];
    logic [N_RANGES-1:0] en_q;
    logic [N_RANGES-1:0] slot_hit;

    // Slot storage: reset clears every slot, a write replaces one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < N_RANGES; s++) begin
                lo_q[s] <= '0;
                hi_q[s] <= '0;
            end
            en_q <= '0;
        end else if (wr_en) begin
            for (int s = 0; s < N_RANGES; s++) begin
                if (wr_slot == SLOT_W'(s)) begin
                    lo_q[s]  <= wr_lo;
                    hi_q[s]  <= wr_hi;
                    en_q[s]  <= wr_valid;
                end
            end
        end
    end

    // One inclusive comparator pair per slot.
    for (genvar g = 0; g < N_RANGES; g++) begin : g_slot
        assign slot_hit[g] = en_q[g] && (probe >= lo_q[g]) && (probe <= hi_q[g]);
    end

    assign hit = |slot_hit;
endmodule

// File: rtl/steer_id_rules.sv
// Module: per-class rules turning enable masks into live steering IDs.
// Pure combinational. For classes that depend on a mask, an empty mask
// yields IDs 0/0 with err set. Assumes N_CU divides evenly into
// N_SLICE quadrants and that every mask is at most 32 bits wide.
module steer_id_rules
    import steer_pkg::*;
#(
    parameter int N_SLICE      = 4,
    parameter int N_CU         = 16,
    parameter int CU_PER_GROUP = 4,
    parameter int L3_FUSE_W    = 3,
    parameter int ID_W         = 4,
    localparam int N_BANK       = 2 * L3_FUSE_W,
    localparam int CU_PER_SLICE = N_CU / N_SLICE
) (
    input  steer_class_e         cls,
    input  logic [L3_FUSE_W-1:0] l3_fuse,
    input  logic [N_SLICE-1:0]   meml3_en,
    input  logic [N_CU-1:0]      cu_en,
    output logic [ID_W-1:0]      grp,
    output logic [ID_W-1:0]      inst,
    output logic                 err
);
    logic [N_BANK-1:0]  bank_mask;
    logic [N_SLICE-1:0] slice_present;
    int                 bank_idx;
    int                 slice_idx;
    int                 cu_idx;

    // Index of the lowest set bit, 0 when none is set.
    function automatic int lowest_set(input logic [31:0] v);
        int r;
        r = 0;
        for (int b = 31; b >= 0; b--) begin
            if (v[b]) r = b;
        end
        return r;
    endfunction

    // Each fuse bit enables a pair of adjacent banks.
    for (genvar i = 0; i < L3_FUSE_W; i++) begin : g_bank
        assign bank_mask[2*i+1:2*i] = {2{l3_fuse[i]}};
    end

    // A slice is present if its memory is enabled or any unit in it is.
    for (genvar k = 0; k < N_SLICE; k++) begin : g_slice
        assign slice_present[k] = meml3_en[k] | (|cu_en[k*CU_PER_SLICE +: CU_PER_SLICE]);
    end

    assign bank_idx  = lowest_set(32'(bank_mask));
    assign slice_idx = lowest_set(32'(slice_present));
    assign cu_idx    = lowest_set(32'(cu_en));

    // Apply the rule of the selected class.
    always_comb begin
        grp  = '0;
        inst = '0;
        err  = 1'b0;
        case (cls)
            CLS_L3: begin
                if (|bank_mask) inst = ID_W'(bank_idx);
                else            err  = 1'b1;
            end
            CLS_MSLICE: begin
                if (|slice_present) grp = ID_W'(slice_idx);
                else                err = 1'b1;
            end
            CLS_LNCF: begin
                if (|slice_present) grp = ID_W'(slice_idx * 2);
                else                err = 1'b1;
            end
            CLS_CU: begin
                if (|cu_en) begin
                    grp  = ID_W'(cu_idx / CU_PER_GROUP);
                    inst = ID_W'(cu_idx % CU_PER_GROUP);
                end else begin
                    err = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/steer_resolver.sv
// Module: top of the address range steering resolver.
// Rebases window offsets, matches them against one range table per
// class, selects the first matching class by priority, applies that
// class's ID rule (or the defaults) and registers the answer.
// Assumes class tables are addressed by steer_pkg class codes.
module steer_resolver
    import steer_pkg::*;
#(
    parameter int ADDR_W       = 22,
    parameter int N_RANGES     = 12,
    parameter int N_SLICE      = 4,
    parameter int N_CU         = 16,
    parameter int CU_PER_GROUP = 4,
    parameter int L3_FUSE_W    = 3,
    parameter int ID_W         = 4,
    parameter int unsigned WIN_LO   = 32'h0003_8000,
    parameter int unsigned WIN_HI   = 32'h0003_FFFF,
    parameter int unsigned WIN_BASE = 32'h0038_0000,
    localparam int SLOT_W = $clog2(N_RANGES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_class,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic [ADDR_W-1:0]    cfg_lo,
    input  logic [ADDR_W-1:0]    cfg_hi,
    input  logic                 cfg_en,
    input  logic [L3_FUSE_W-1:0] l3_fuse,
    input  logic [N_SLICE-1:0]   meml3_en,
    input  logic [N_CU-1:0]      cu_en,
    input  logic [ID_W-1:0]      dflt_group,
    input  logic [ID_W-1:0]      dflt_inst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_offset,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [2:0]           rsp_class,
    output logic [ID_W-1:0]      rsp_group,
    output logic [ID_W-1:0]      rsp_inst,
    output logic                 rsp_err
);
    logic [ADDR_W-1:0]  probe;
    logic [N_CLASS-1:0] class_hit;
    steer_class_e       sel_cls;
    logic [ID_W-1:0]    rule_grp;
    logic [ID_W-1:0]    rule_inst;
    logic               rule_err;

    // Rebase offsets that fall in the secondary window.
    always_comb begin
        if ({10'd0, req_offset} >= WIN_LO && {10'd0, req_offset} <= WIN_HI)
            probe = req_offset + ADDR_W'(WIN_BASE);
        else
            probe = req_offset;
    end

    // One range table per class, written through the shared config port.
    for (genvar c = 0; c < N_CLASS; c++) begin : g_tbl
        steer_range_table #(
            .ADDR_W   (ADDR_W),
            .N_RANGES (N_RANGES)
        ) u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && (cfg_class == 3'(c))),
            .wr_slot  (cfg_slot),
            .wr_lo    (cfg_lo),
            .wr_hi    (cfg_hi),
            .wr_valid (cfg_en),
            .probe    (probe),
            .hit      (class_hit[c])
        );
    end

    // Fixed priority: the lowest class code that matches wins.
    always_comb begin
        sel_cls = CLS_NONE;
        for (int c = N_CLASS - 1; c >= 0; c--) begin
            if (class_hit[c]) sel_cls = steer_class_e'(3'(c));
        end
    end

    steer_id_rules #(
        .N_SLICE      (N_SLICE),
        .N_CU         (N_CU),
        .CU_PER_GROUP (CU_PER_GROUP),
        .L3_FUSE_W    (L3_FUSE_W),
        .ID_W         (ID_W)
    ) u_rules (
        .cls      (sel_cls),
        .l3_fuse  (l3_fuse),
        .meml3_en (meml3_en),
        .cu_en    (cu_en),
        .grp      (rule_grp),
        .inst     (rule_inst),
        .err      (rule_err)
    );

    // Response register: loads on a request, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_class <= CLS_NONE;
            rsp_group <= '0;
            rsp_inst  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit   <= (sel_cls != CLS_NONE);
                rsp_class <= sel_cls;
                rsp_group <= (sel_cls == CLS_NONE) ? dflt_group : rule_grp;
                rsp_inst  <= (sel_cls == CLS_NONE) ? dflt_inst  : rule_inst;
                rsp_err   <= (sel_cls == CLS_NONE) ? 1'b0       : rule_err;
            end
        end
    end

    // R10: response valid trails the request by exactly one cycle.
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: a lookup no table claims returns the sampled defaults.
    a_r3_default_ids: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(|class_hit)) |=> (!rsp_hit && rsp_class == CLS_NONE && !rsp_err
            && rsp_group == $past(dflt_group) && rsp_inst == $past(dflt_inst)));

    // R2: an L3 match outranks every other class.
    a_r2_l3_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && class_hit[CLS_L3]) |=> (rsp_hit && rsp_class == CLS_L3));

    // R9: an error answer always carries IDs 0/0 from a matched class.
    a_r9_err_zero_ids: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_hit && rsp_group == '0 && rsp_inst == '0));

    // R8: fixed-zero class never reports nonzero IDs or an error.
    a_r8_zero_class: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && rsp_class == CLS_ZERO) |-> (rsp_group == '0 && rsp_inst == '0 && !rsp_err));

    // R5: banks come in pairs, so an L3 instance is always even, group 0.
    a_r5_l3_even: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && rsp_class == CLS_L3) |-> (rsp_group == '0 && !rsp_inst[0]));
endmodule

// File: tb/steer_resolver_bench.sv
`timescale 1ns/1ps
module steer_resolver_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_class = '0;
    logic [3:0]  cfg_slot = '0;
    logic [21:0] cfg_lo = '0;
    logic [21:0] cfg_hi = '0;
    logic        cfg_en = 1'b0;
    logic [2:0]  l3_fuse = '0;
    logic [3:0]  meml3_en = '0;
    logic [15:0] cu_en = '0;
    logic [3:0]  dflt_group = '0;
    logic [3:0]  dflt_inst = '0;
    logic        req_valid = 1'b0;
    logic [21:0] req_offset = '0;
    logic        rsp_valid, rsp_hit, rsp_err;
    logic [2:0]  rsp_class;
    logic [3:0]  rsp_group, rsp_inst;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // Bench copy of the range tables.
    logic [21:0] m_lo [5][12];
    logic [21:0] m_hi [5][12];
    bit          m_en [5][12];

    // Expected response fields.
    bit       e_hit, e_err;
    int       e_cls, e_grp, e_inst;

    always #2 clk = ~clk;

    steer_resolver u_steer_resolver (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_class(cfg_class),
        .cfg_slot(cfg_slot), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_en(cfg_en),
        .l3_fuse(l3_fuse), .meml3_en(meml3_en), .cu_en(cu_en),
        .dflt_group(dflt_group), .dflt_inst(dflt_inst),
        .req_valid(req_valid), .req_offset(req_offset),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_class(rsp_class),
        .rsp_group(rsp_group), .rsp_inst(rsp_inst), .rsp_err(rsp_err)
    );

    // Expected answer from the requirements (R1..R9).
    task automatic compute_expected(input logic [21:0] off);
        int a;
        int f;
        int present;
        a = int'(off);
        if (a >= 'h38000 && a <= 'h3FFFF) a = (a + 'h380000) % (1 << 22);  // R4
        e_cls = 7;
        for (int c = 4; c >= 0; c--)
            for (int s = 0; s < 12; s++)
                if (m_en[c][s] && a >= int'(m_lo[c][s]) && a <= int'(m_hi[c][s])) e_cls = c;
        e_hit = (e_cls != 7);
        e_err = 1'b0;
        e_grp = 0;
        e_inst = 0;
        case (e_cls)
            0: begin  // R5
                f = -1;
                for (int i = 2; i >= 0; i--) if (l3_fuse[i]) f = i;
                if (f < 0) e_err = 1'b1; else e_inst = 2 * f;
            end
            1, 2: begin  // R6
                present = -1;
                for (int k = 3; k >= 0; k--)
                    if (meml3_en[k] || cu_en[4*k +: 4] != 4'd0) present = k;
                if (present < 0) e_err = 1'b1;
                else e_grp = (e_cls == 2) ? 2 * present : present;
            end
            3: begin  // R7
                f = -1;
                for (int b = 15; b >= 0; b--) if (cu_en[b]) f = b;
                if (f < 0) e_err = 1'b1;
                else begin e_grp = f / 4; e_inst = f % 4; end
            end
            4: ;  // R8
            default: begin e_grp = int'(dflt_group); e_inst = int'(dflt_inst); end  // R3
        endcase
    endtask

    task automatic report(input string tag, input logic [12:0] act, input logic [12:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act{hit,cls,grp,inst,err}=%h exp=%h", tag, act, exp);
        end
    endtask

    // One lookup, checked one cycle later.
    task automatic lookup(input string tag, input logic [21:0] off);
        @(negedge clk);
        req_valid = 1'b1;
        req_offset = off;
        compute_expected(off);
        @(negedge clk);
        req_valid = 1'b0;
        report(tag, {rsp_hit, rsp_class, rsp_group, rsp_inst, rsp_err},
               {e_hit, 3'(e_cls), 4'(e_grp), 4'(e_inst), e_err});
    endtask

    task automatic cfg_write(input int cls, input int slot, input int lo, input int hi, input bit en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_class = 3'(cls); cfg_slot = 4'(slot);
        cfg_lo = 22'(lo); cfg_hi = 22'(hi); cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
        m_lo[cls][slot] = 22'(lo); m_hi[cls][slot] = 22'(hi); m_en[cls][slot] = en;
    endtask

    // Test the bounds of every enabled slot (R1, R2, R4).
    task automatic sweep_bounds();
        for (int c = 0; c < 5; c++)
            for (int s = 0; s < 12; s++)
                if (m_en[c][s]) begin
                    lookup("R1 lo-1", m_lo[c][s] - 22'd1);
                    lookup("R1 lo", m_lo[c][s]);
                    lookup("R1 hi", m_hi[c][s]);
                    lookup("R1 hi+1", m_hi[c][s] + 22'd1);
                end
    endtask

    initial begin
        for (int c = 0; c < 5; c++)
            for (int s = 0; s < 12; s++) begin
                m_lo[c][s] = '0; m_hi[c][s] = '0; m_en[c][s] = 1'b0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        report("R10 reset state", {rsp_valid, rsp_hit, rsp_class, 4'd0, 4'd0},
               {1'b0, 1'b0, 3'd7, 4'd0, 4'd0});

        dflt_group = 4'h9; dflt_inst = 4'h3;
        l3_fuse = 3'b110; cu_en = 16'hF0A0; meml3_en = 4'b0000;
        lookup("R1 empty tables miss", 22'h00B200);
        lookup("R3 default ids", 22'h004000);

        cfg_write(0, 0, 'hB100, 'hB3FF, 1'b1);
        cfg_write(1, 0, 'hDD00, 'hDDFF, 1'b1);
        cfg_write(1, 5, 'hE900, 'hFFFF, 1'b1);
        cfg_write(2, 0, 'hB000, 'hB0FF, 1'b1);
        cfg_write(2, 1, 'hD800, 'hD8FF, 1'b1);
        cfg_write(3, 0, 'h5200, 'h52FF, 1'b1);
        cfg_write(3, 1, 'hDE80, 'hE8FF, 1'b1);
        cfg_write(3, 2, 'hB100, 'hB1FF, 1'b1);
        cfg_write(4, 0, 'h4000, 'h4AFF, 1'b1);
        cfg_write(4, 11, 'h3BB200, 'h3BB23F, 1'b1);

        sweep_bounds();
        lookup("R2 overlap L3 over CU", 22'h00B150);
        lookup("R4 window rebased", 22'h03B210);
        lookup("R4 window edge lo", 22'h038000);
        lookup("R4 unrebased direct", 22'h3BB210);
        lookup("R4 window edge hi", 22'h03FFFF);

        for (int f = 0; f < 8; f++) begin
            l3_fuse = 3'(f);
            lookup("R5 l3 fuse sweep", 22'h00B200);
            lookup("R9 l3 fuse sweep err", 22'h00B300);
        end
        l3_fuse = 3'b110;

        cu_en = 16'h0000;
        for (int m = 0; m < 16; m++) begin
            meml3_en = 4'(m);
            lookup("R6 mslice meml3 sweep", 22'h00DD10);
            lookup("R6 lncf meml3 sweep", 22'h00D810);
        end
        meml3_en = 4'b0000;
        for (int b = 0; b <= 16; b++) begin
            cu_en = (b == 16) ? 16'h0000 : (16'hFFFF << b);
            lookup("R7 cu walking", 22'h005280);
            lookup("R6 slice from cu", 22'h00F000);
            lookup("R6 lncf from cu", 22'h00B010);
            lookup("R9 empty mask", 22'h00E000);
        end
        cu_en = 16'h0000;
        lookup("R8 zero class no err", 22'h004800);
        cu_en = 16'hF0A0;

        for (int d = 0; d < 16; d++) begin
            dflt_group = 4'(d); dflt_inst = 4'(15 - d);
            lookup("R3 default sweep", 22'h001000);
        end

        // R11: same-cycle write and lookup sees old table; next sees new.
        @(negedge clk);
        cfg_we = 1'b1; cfg_class = 3'd0; cfg_slot = 4'd0;
        cfg_lo = 22'h00B100; cfg_hi = 22'h00B3FF; cfg_en = 1'b0;
        req_valid = 1'b1; req_offset = 22'h00B150;
        compute_expected(22'h00B150);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        m_en[0][0] = 1'b0;
        report("R11 same-cycle old contents", {rsp_hit, rsp_class, rsp_group, rsp_inst, rsp_err},
               {e_hit, 3'(e_cls), 4'(e_grp), 4'(e_inst), e_err});
        lookup("R11 new contents to CU", 22'h00B150);
        lookup("R11 cleared slot misses", 22'h00B300);

        // R10: fields hold while no request is made.
        repeat (3) @(negedge clk);
        report("R10 hold when idle", {rsp_valid, rsp_hit, rsp_class, rsp_group, rsp_inst},
               {1'b0, e_hit, 3'(e_cls), 4'(e_grp), 4'(e_inst)});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired act=hung exp=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule